// File: doc/BRIEF.md
# Spike Window Capture and Peak Alignment

This block sits behind a spike detector in a neural recording chain. It keeps a running circular history of the incoming signed samples. When the detector flags a threshold crossing, the block freezes a window of samples around that point. The window holds 22 samples before the crossing, the crossing sample itself and 50 samples after it.

Once the window is complete, the block walks through it and finds the sample with the steepest rise. The rise of a sample is that sample minus the one before it. The block then streams out a 48-sample snippet, placed so that the steepest rise falls on the 11th output sample wherever the window allows. Snippets from different spikes therefore line up on a common feature, not on the arbitrary point where the threshold was crossed.

While a window is being gathered, scanned or sent, the block reports itself busy and takes no new detection.

Top module: `spk_align`

## Requirements
- R1: In every cycle after a clock edge with `rst` high, `busy`, `out_valid` and `out_last` are low.
- R2: A detection is taken only at a clock edge where `detect` and `in_valid` are both high and `busy` is low. A `detect` without `in_valid`, or one while `busy` is high, starts no capture and produces no snippet.
- R3: The window holds 73 samples in order:
  - the 22 samples accepted before the detection;
  - the sample accepted with it (window index 22);
  - the next 50 samples accepted with `in_valid` high, including those after cycles where `in_valid` is low.
  
  Samples presented after the 50th post-crossing sample, while `busy` is high, are not stored and do not alter the window or later windows.
- R4: The rise at window index i (1 to 72) is the signed difference sample[i] − sample[i−1] of the two's-complement samples. The peak is the index with the largest rise; the lowest index wins a tie.
- R5: The snippet is window samples start to start+47. Here start = peak − 10, raised to 0 if negative and lowered to 25 if above 25. So an unclamped peak appears as output position 10 (the 11th sample).
- R6: The 48 snippet samples come out on consecutive cycles with `out_valid` high. `out_last` is high on the 48th sample only.
- R7: Timing is counted from the clock edge that accepts the 50th post-crossing sample:
  - the first snippet sample is valid in the cycle after the 76th clock edge following that edge;
  - `busy` goes high in the cycle after the accepting edge of the detection;
  - `busy` stays high through the cycle with `out_last`, and goes low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is presented on `in_data` this cycle |
| in_data | input | 10 | Signed two's-complement sample |
| detect | input | 1 | Threshold crossing at the sample presented this cycle |
| busy | output | 1 | A capture, scan or snippet output is in progress |
| out_valid | output | 1 | `out_data` carries a snippet sample |
| out_last | output | 1 | Final (48th) sample of the snippet |
| out_data | output | 10 | Signed snippet sample |

## Verification
`busy` is due in the cycle right after the edge that accepts a detection. The snippet starts a fixed 76 cycles after the edge that completes the capture and runs for 48 consecutive cycles. `busy` drops in the cycle after `out_last`.

A behavioural model advances on each rising edge from the inputs it saw. It predicts the value each output must show in the cycle that follows. The outputs are compared against it at the falling edge, halfway through that cycle.

The stimulus places the steepest rise in several positions:
- well inside the window;
- at the first and last rise positions;
- near both clamp limits;
- at the crossing sample;
- as a tie between two equal rises.

It also adds input gaps during capture, samples and detections pushed in while busy, and detections without a valid sample.

// File: rtl/spk_pkg.sv
package spk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAPT,
    ST_SCAN,
    ST_EMIT
  } spk_state_e;

endpackage

// File: rtl/spk_hist_ram.sv
// Circular sample history: one write port, one registered read port,
// written in a form that maps onto block RAM.
module spk_hist_ram #(
  parameter int DW    = 10,
  parameter int DEPTH = 73,
  parameter int AW    = 7
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [DW-1:0] wdata,
  input  logic                 re,
  input  logic [AW-1:0]        raddr,
  output logic signed [DW-1:0] rdata
);

  logic signed [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/spk_peak_scan.sv
// Consumes the window one sample per valid beat, index 0 first, and keeps
// the index of the largest first difference (lowest index on ties).
module spk_peak_scan #(
  parameter int DW = 10,
  parameter int W  = 73,
  parameter int IW = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_v,
  input  logic [IW-1:0]        in_idx,
  input  logic signed [DW-1:0] in_data,
  output logic                 done,
  output logic [IW-1:0]        peak_idx
);

  logic signed [DW-1:0] prev_q;
  logic signed [DW:0]   best_q;
  logic signed [DW:0]   diff;
  logic                 take;

  assign diff = {in_data[DW-1], in_data} - {prev_q[DW-1], prev_q};
  assign take = in_v && (in_idx != '0) &&
                ((in_idx == IW'(1)) || (diff > best_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      best_q   <= '0;
      peak_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= in_v && (in_idx == IW'(W-1));
      if (in_v) prev_q <= in_data;
      if (take) begin
        best_q   <= diff;
        peak_idx <= in_idx;
      end
    end
  end

endmodule

// File: rtl/spk_align.sv
module spk_align #(
  parameter int DW       = 10,
  parameter int PRE      = 22,
  parameter int POST     = 50,
  parameter int OUT_LEN  = 48,
  parameter int PEAK_POS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 detect,
  output logic                 busy,
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [DW-1:0] out_data
);
  import spk_pkg::*;

  localparam int W        = PRE + 1 + POST;
  localparam int AW       = $clog2(W);
  localparam int OW       = $clog2(W + 1);
  localparam int CW       = $clog2(POST + 1);
  localparam int MAXSTART = W - OUT_LEN;

  spk_state_e           state_q;
  logic [AW-1:0]        wr_ptr_q, base_q, wr_nxt, raddr;
  logic [CW-1:0]        cnt_q;
  logic [OW-1:0]        off_q, start_q, rel, st_calc, peak_idx;
  logic [OW:0]          sum;
  logic                 we, re, scan_rd, emit_rd;
  logic                 sc_v_q, sc_done, ov_q, ol_q;
  logic [OW-1:0]        sc_idx_q;
  logic signed [DW-1:0] rdata;

  assign we      = in_valid && (state_q == ST_IDLE || state_q == ST_CAPT);
  assign wr_nxt  = (wr_ptr_q == AW'(W-1)) ? '0 : wr_ptr_q + 1'b1;
  assign scan_rd = (state_q == ST_SCAN) && (off_q < OW'(W));
  assign emit_rd = (state_q == ST_EMIT) && (off_q < OW'(OUT_LEN));
  assign re      = scan_rd || emit_rd;

  // Window offset to physical address, wrapping round the circular buffer.
  assign rel   = scan_rd ? off_q : start_q + off_q;
  assign sum   = (OW+1)'(base_q) + (OW+1)'(rel);
  assign raddr = (sum >= (OW+1)'(W)) ? AW'(sum - (OW+1)'(W)) : AW'(sum);

  // Snippet start: peak minus its target position, held inside the window.
  always_comb begin
    if (peak_idx < OW'(PEAK_POS))
      st_calc = '0;
    else if (peak_idx > OW'(PEAK_POS + MAXSTART))
      st_calc = OW'(MAXSTART);
    else
      st_calc = peak_idx - OW'(PEAK_POS);
  end

  spk_hist_ram #(.DW(DW), .DEPTH(W), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (wr_ptr_q),
    .wdata (in_data),
    .re    (re),
    .raddr (raddr),
    .rdata (rdata)
  );

  spk_peak_scan #(.DW(DW), .W(W), .IW(OW)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .in_v     (sc_v_q),
    .in_idx   (sc_idx_q),
    .in_data  (rdata),
    .done     (sc_done),
    .peak_idx (peak_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      wr_ptr_q <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      off_q    <= '0;
      start_q  <= '0;
      sc_v_q   <= 1'b0;
      sc_idx_q <= '0;
      ov_q     <= 1'b0;
      ol_q     <= 1'b0;
    end else begin
      if (we) wr_ptr_q <= wr_nxt;
      sc_v_q   <= scan_rd;
      sc_idx_q <= off_q;
      ov_q     <= emit_rd;
      ol_q     <= emit_rd && (off_q == OW'(OUT_LEN-1));
      case (state_q)
        ST_IDLE: begin
          if (in_valid && detect) begin
            state_q <= ST_CAPT;
            cnt_q   <= '0;
          end
        end
        ST_CAPT: begin
          if (in_valid) begin
            if (cnt_q == CW'(POST-1)) begin
              state_q <= ST_SCAN;
              base_q  <= wr_nxt;
              off_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_SCAN: begin
          if (scan_rd) off_q <= off_q + 1'b1;
          if (sc_done) begin
            state_q <= ST_EMIT;
            start_q <= st_calc;
            off_q   <= '0;
          end
        end
        ST_EMIT: begin
          if (emit_rd) off_q <= off_q + 1'b1;
          if (ol_q) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign out_valid = ov_q;
  assign out_last  = ol_q;
  assign out_data  = rdata;

endmodule

// File: rtl/spk_align_chk.sv
module spk_align_chk #(
  parameter int OUT_LEN = 48
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic detect,
  input logic busy,
  input logic out_valid,
  input logic out_last
);

  int vcnt;

  always_ff @(posedge clk) begin
    if (rst) vcnt <= 0;
    else if (out_valid) vcnt <= out_last ? 0 : vcnt + 1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!busy && !out_valid && !out_last));

  p_busy_needs_detect_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(in_valid && detect));

  p_last_is_valid_r6: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  p_snippet_length_r6: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (vcnt == OUT_LEN - 1));

  p_valid_inside_busy_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  p_busy_ends_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(out_last));

endmodule

bind spk_align spk_align_chk #(.OUT_LEN(OUT_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .detect    (detect),
  .busy      (busy),
  .out_valid (out_valid),
  .out_last  (out_last)
);

// File: tb/tb_spk_align.sv
module tb_spk_align;
  localparam int DW = 10, PRE = 22, POST = 50, OUT_LEN = 48, PEAK_POS = 10;
  localparam int W = PRE + 1 + POST;
  localparam int MAXSTART = W - OUT_LEN;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, detect = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic busy, out_valid, out_last;
  logic signed [DW-1:0] out_data;

  int vectors = 0, fails = 0, nsnip = 0, sn = 0;
  int snip [64];
  bit started = 0, finished = 0;

  // model state
  int hist [$];
  int win [W];
  int mphase = 0, mcnt = 0, mt = 0, mstart = 0;
  bit eb = 0, ev = 0, el = 0;
  int ed = 0;

  spk_align #(.DW(DW), .PRE(PRE), .POST(POST), .OUT_LEN(OUT_LEN), .PEAK_POS(PEAK_POS)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .detect(detect),
    .busy(busy), .out_valid(out_valid), .out_last(out_last), .out_data(out_data));

  always #5 clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clamp_start(int p);
    int s = p - PEAK_POS;
    if (s < 0) s = 0;
    if (s > MAXSTART) s = MAXSTART;
    return s;
  endfunction

  // Behavioural reference, advanced on each rising edge.
  always @(posedge clk) begin
    started = 1;
    ev = 0; el = 0;
    if (rst) begin
      mphase = 0; hist.delete(); eb = 0;
    end else begin
      case (mphase)
        0: if (in_valid) begin
             hist.push_back(int'(in_data));
             if (hist.size() > W) void'(hist.pop_front());
             if (detect) begin mphase = 1; mcnt = 0; end
           end
        1: if (in_valid) begin
             int best, peak;
             hist.push_back(int'(in_data));
             if (hist.size() > W) void'(hist.pop_front());
             mcnt++;
             if (mcnt == POST) begin
               for (int i = 0; i < W; i++) win[i] = hist[hist.size() - W + i];
               best = 0; peak = 1;
               for (int i = 1; i < W; i++) begin
                 if (i == 1 || (win[i] - win[i-1]) > best) begin
                   best = win[i] - win[i-1]; peak = i;
                 end
               end
               mstart = clamp_start(peak);
               mphase = 2; mt = 0;
             end
           end
        default: begin
          mt++;
          if (mt >= W + 3 && mt <= W + 2 + OUT_LEN) begin
            ev = 1; ed = win[mstart + mt - (W + 3)]; el = (mt == W + 2 + OUT_LEN);
          end
          if (mt == W + 3 + OUT_LEN) mphase = 0;
        end
      endcase
      eb = (mphase != 0);
    end
  end

  // Compare halfway through every cycle.
  always @(negedge clk) begin
    if (started && !finished) begin
      check(busy == eb, "R7 busy", int'(busy), int'(eb));
      check(out_valid == ev, "R6 out_valid", int'(out_valid), int'(ev));
      check(out_last == el, "R6 out_last", int'(out_last), int'(el));
      if (ev) check(int'(out_data) == ed, "R3/R4/R5 out_data", int'(out_data), ed);
      if (out_valid && sn < 64) begin snip[sn] = int'(out_data); sn++; end
      if (out_last) nsnip++;
    end
  end

  function automatic int sval(int j, int p, int q, int base, int seed, bit flat);
    if (flat) return (j == p || j == q) ? 200 : 0;
    return base + ((j * 37 + seed * 11) % 17) - 8 + ((j == p) ? 300 : 0);
  endfunction

  task automatic spike(int p, int q, int base, int seed, bit gap, bit flat);
    int k, dv;
    sn = 0;
    for (int j = 0; j < W; j++) begin
      if (gap && (j % 3 == 2)) begin
        @(negedge clk); in_valid = 0; detect = 0;
      end
      @(negedge clk);
      in_valid = 1; in_data = DW'(sval(j, p, q, base, seed, flat)); detect = (j == PRE);
    end
    for (int c = 0; c < 1000; c++) begin
      @(negedge clk);
      if (!busy) break;
      in_valid = 1; in_data = DW'(450); detect = (c % 5 == 0);
    end
    in_valid = 0; detect = 0;
    @(negedge clk); detect = 1;
    @(negedge clk); detect = 0;
    k  = p - clamp_start(p);
    dv = sval(p, p, q, base, seed, flat) - sval(p - 1, p, q, base, seed, flat);
    check(sn == OUT_LEN, "R6 snippet length", sn, OUT_LEN);
    check(snip[k] - snip[k-1] == dv, "R5 peak position", snip[k] - snip[k-1], dv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check(!busy && !out_valid && !out_last, "R1 reset state",
          int'({busy, out_valid, out_last}), 0);
    @(negedge clk); detect = 1;          // detect without a sample: R2
    @(negedge clk); detect = 0;
    @(negedge clk);
    check(busy == 1'b0, "R2 detect without in_valid", int'(busy), 0);
    spike(30, -1,    0, 1, 0, 0);        // unclamped peak
    spike( 3, -1, -400, 2, 1, 0);        // low clamp, gaps
    spike(70, -1,  100, 3, 0, 0);        // high clamp
    spike(25, 33,    0, 0, 0, 1);        // tie: earliest wins (R4)
    spike(22, -1,  -50, 5, 1, 0);        // peak on crossing sample
    spike( 1, -1,    0, 6, 0, 0);        // first rise position
    spike(72, -1, -200, 7, 1, 0);        // last rise position
    repeat (4) @(negedge clk);
    check(nsnip == 7, "R2 detects while busy ignored", nsnip, 7);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      vectors++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule